// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Driver

The block takes a serial bit stream into a shift chain on one clock and copies the whole chain into a holding register on a second, independent clock. The held bits control a bank of open-drain output pins. Because the two stages are clocked apart, new data can be shifted in while the pins keep showing the previously latched pattern. The pins change only when the storage clock fires. The last stage of the shift chain is brought out as a cascade tap. Wiring that tap to the serial input of another copy of the block forms a longer chain.

An active-low clear empties both registers at once and does not wait for either clock. Its release is retimed separately into each clock domain. An active-low enable gates the pin drivers only and never touches the stored bits. The serial input is a plain level that is sampled on the shift clock. There is no valid/ready handshake and no back-pressure: every rising shift edge consumes one bit. The held contents are also available as a parallel read-out for observation.

Top module: `sd_latch_driver`

## Requirements
- R1: On each rising edge of `sh_clk`, every shift stage i moves to stage i+1 and `sdi` enters stage 0. A byte sent most significant bit first is therefore held with its bit 7 in stage 7 after eight edges.
- R2: On each rising edge of `st_clk`, all shift stages are copied into the holding register. `latch_q[i]` equals stage i.
- R3: `cas_o` always equals stage W-1 and changes only on rising `sh_clk` edges. The first bit sent appears there after W edges. Feeding `cas_o` into a second block's `sdi` and sending 2W bits leaves the first W bits in the second block.
- R4: While `clr_n` is low, both registers read zero and `cas_o` is 0, with no clock edge needed.
- R5: After `clr_n` rises, the first SYNC_STAGES (default 2) rising edges of each clock leave that domain's register cleared. The next edge acts normally.
- R6: With `oe_n` low, pin i is driven to 0 when `latch_q[i]` is 1 and is released (high impedance) when it is 0. Under a pull-up, the pins read as the inverse of `latch_q`.
- R7: With `oe_n` high, all W pins are released to high impedance.
- R8: Changing `oe_n` never alters the holding register or the shift chain.
- R9: When `sh_clk` and `st_clk` are the same signal, the holding register receives the shift contents from before that edge. It therefore always lags the chain by one pulse.
- R10: Rising `sh_clk` edges with no `st_clk` edge leave `latch_q` and the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_clk | input | 1 | Shift clock, rising edge active |
| st_clk | input | 1 | Storage clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| oe_n | input | 1 | Pin driver enable, active low |
| sdi | input | 1 | Serial data in |
| cas_o | output | 1 | Cascade tap, last shift stage |
| pin_o | output | W | Open-drain outputs: 0 or high impedance |
| latch_q | output | W | Parallel view of the holding register |

## Verification
Distinct bytes (0xA5, 0x3C, 0x96, 0x5A, 0xC3) are shifted one edge at a time. This separates a correct stage order and bit direction from a reversed or stuck chain. The cascade tap is compared on every edge. A two-block chain shows that bits leave stage 7 in order. Tied-clock pulses separate a storage stage that lags by one pulse from one that samples the newly shifted value. Enable toggling is followed by further shifting, so any disturbance of the chain would appear on the tap. Clearing without clocks and then counting the absorbed edges after release shows that the clear acts asynchronously and that its release is retimed in each domain.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int SD_WIDTH_DEF = 8;
  localparam int SD_SYNC_DEF  = 2;
endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  localparam logic [STAGES-1:0] ONE = STAGES'(1);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= (chain << 1) | ONE;
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/sd_shift_stage.sv
module sd_shift_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  output logic [W-1:0] bits_q,
  output logic         cas_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= {bits_q[W-2:0], sdi};
  end

  assign cas_o = bits_q[W-1];

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> bits_q == {$past(bits_q[W-2:0]), $past(sdi)});

  // R3
  cascade_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cas_o == $past(bits_q[W-2]));

  // R4
  shift_clear_chk: assert property (@(posedge clk)
    !rst_n |-> bits_q == '0);
endmodule

// File: rtl/sd_store_stage.sv
module sd_store_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end

  // R2
  store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q_o == $past(d_i));

  // R4
  store_clear_chk: assert property (@(posedge clk)
    !rst_n |-> q_o == '0);
endmodule

// File: rtl/sd_od_drive.sv
module sd_od_drive #(
  parameter int W = 8
) (
  input  logic         oe_n,
  input  logic [W-1:0] lat_i,
  output wire  [W-1:0] pin_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_o[i] = (!oe_n && lat_i[i]) ? 1'b0 : 1'bz;
  end
endmodule

// File: rtl/sd_latch_driver.sv
module sd_latch_driver
  import sd_pkg::*;
#(
  parameter int W      = SD_WIDTH_DEF,
  parameter int STAGES = SD_SYNC_DEF
) (
  input  logic         sh_clk,
  input  logic         st_clk,
  input  logic         clr_n,
  input  logic         oe_n,
  input  logic         sdi,
  output logic         cas_o,
  output wire  [W-1:0] pin_o,
  output logic [W-1:0] latch_q
);
  logic         sh_rst_n;
  logic         st_rst_n;
  logic [W-1:0] sh_bits;

  sd_rst_sync #(.STAGES(STAGES)) u_sh_sync (
    .clk(sh_clk), .clr_n(clr_n), .rst_n(sh_rst_n));

  sd_rst_sync #(.STAGES(STAGES)) u_st_sync (
    .clk(st_clk), .clr_n(clr_n), .rst_n(st_rst_n));

  sd_shift_stage #(.W(W)) u_shift (
    .clk(sh_clk), .rst_n(sh_rst_n), .sdi(sdi),
    .bits_q(sh_bits), .cas_o(cas_o));

  sd_store_stage #(.W(W)) u_store (
    .clk(st_clk), .rst_n(st_rst_n), .d_i(sh_bits), .q_o(latch_q));

  sd_od_drive #(.W(W)) u_drive (
    .oe_n(oe_n), .lat_i(latch_q), .pin_o(pin_o));
endmodule

// File: tb/sim_sd_latch_driver.sv
module sim_sd_latch_driver;
  logic clk = 1'b0;
  logic sh_clk = 1'b0, st_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b1, sdi = 1'b0;
  logic       cas0, cas1;
  logic [7:0] lat0, lat1;
  tri1  [7:0] pins0;
  tri1  [7:0] pins1;
  int n_chk = 0, n_err = 0;
  logic done = 1'b0;
  logic [7:0] m_sh = '0, m_lat = '0, m1_sh = '0, m1_lat = '0;

  always #4 clk = ~clk;

  sd_latch_driver u0 (.sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
    .sdi(sdi), .cas_o(cas0), .pin_o(pins0), .latch_q(lat0));
  sd_latch_driver u1 (.sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
    .sdi(cas0), .cas_o(cas1), .pin_o(pins1), .latch_q(lat1));

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sh_pulse(input logic b);
    sdi = b;
    #4 sh_clk = 1'b1;
    m1_sh = {m1_sh[6:0], m_sh[7]};
    m_sh  = {m_sh[6:0], b};
    #4 sh_clk = 1'b0;
  endtask

  task automatic st_pulse();
    #4 st_clk = 1'b1;
    m_lat = m_sh; m1_lat = m1_sh;
    #4 st_clk = 1'b0;
  endtask

  task automatic tie_pulse(input logic b);
    sdi = b;
    #4 begin sh_clk = 1'b1; st_clk = 1'b1; end
    m_lat = m_sh; m1_lat = m1_sh;
    m1_sh = {m1_sh[6:0], m_sh[7]};
    m_sh  = {m_sh[6:0], b};
    #4 begin sh_clk = 1'b0; st_clk = 1'b0; end
  endtask

  task automatic settle();
    clr_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      sdi = 1'b0;
      #4 begin sh_clk = 1'b1; st_clk = 1'b1; end
      #4 begin sh_clk = 1'b0; st_clk = 1'b0; end
    end
  endtask

  task automatic t_reset();
    #5;
    chk("R4", "latch at reset", lat0, 8'h00);
    chk("R4", "pins at reset", pins0, 8'hFF);
    chk("R4", "cascade at reset", {7'd0, cas0}, 8'h00);
    settle();
  endtask

  task automatic t_shift_latch();
    for (int i = 7; i >= 0; i--) begin
      sh_pulse(8'hA5 >> i);
      chk("R3", "cascade per edge", {7'd0, cas0}, {7'd0, m_sh[7]});
      chk("R10", "latch steady while shifting", lat0, 8'h00);
    end
    chk("R1", "cascade after byte", {7'd0, cas0}, 8'h01);
    st_pulse();
    chk("R2", "latched byte", lat0, 8'hA5);
    oe_n = 1'b0; #2;
    chk("R6", "pins enabled", pins0, 8'h5A);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #2;
    chk("R7", "pins disabled", pins0, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      #3 oe_n = ~oe_n;
      #3 chk("R8", "latch across enable toggle", lat0, 8'hA5);
    end
    chk("R6", "pins after toggles", pins0, 8'h5A);
    for (int i = 7; i >= 0; i--) begin
      sh_pulse(8'h3C >> i);
      chk("R8", "chain intact after toggles", {7'd0, cas0}, {7'd0, m_sh[7]});
    end
    chk("R10", "pins unchanged by shifting", pins0, 8'h5A);
    st_pulse();
    chk("R1", "second byte", lat0, 8'h3C);
  endtask

  task automatic t_tied();
    for (int i = 7; i >= 0; i--) tie_pulse(8'h96 >> i);
    chk("R9", "tied clocks lag", lat0, m_lat);
    chk("R9", "tied clocks value", lat0, {8'h3C << 7} | (8'h96 >> 1));
    tie_pulse(1'b0);
    chk("R9", "tied clocks final", lat0, 8'h96);
  endtask

  task automatic t_cascade();
    for (int i = 7; i >= 0; i--) sh_pulse(8'h5A >> i);
    for (int i = 7; i >= 0; i--) sh_pulse(8'hC3 >> i);
    st_pulse();
    chk("R3", "near block", lat0, 8'hC3);
    chk("R3", "far block", lat1, 8'h5A);
    chk("R3", "far cascade", {7'd0, cas1}, 8'h00);
  endtask

  task automatic t_clear();
    oe_n = 1'b0; #3;
    clr_n = 1'b0; #3;
    chk("R4", "latch cleared", lat0, 8'h00);
    chk("R4", "far latch cleared", lat1, 8'h00);
    chk("R4", "pins released", pins0, 8'hFF);
    chk("R4", "cascade cleared", {7'd0, cas0}, 8'h00);
    #5 clr_n = 1'b1;
    for (int k = 0; k < 3; k++) sh_pulse(1'b1);
    st_pulse(); st_pulse();
    chk("R5", "storage absorbs first edges", lat0, 8'h00);
    st_pulse();
    chk("R5", "only third shift counted", lat0, 8'h01);
    chk("R6", "pins after clear", pins0, 8'hFE);
  endtask

  initial begin
    t_reset();
    t_shift_latch();
    t_oe();
    t_tied();
    t_cascade();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule